// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a virtual address into a physical address through a two-level table walk. The virtual address carries a segment number, a page number and a byte offset. The block reads the segment entry at the segment-table pointer plus the segment number. It checks that the segment is resident and that the page number lies inside the segment's length. It then reads the page entry at the segment's page-table base plus the page number. The frame number from that entry is joined with the offset to form the physical address.

Both tables sit in one small internal synchronous memory. Software fills that memory through a load port while the walker is idle. Each request ends with a one-cycle completion pulse that carries either a physical address or a fault code. A write access that completes without a fault marks its segment as modified by writing the segment entry back with the modified bit set.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, busy_o, done_o and fault_o are all low.
- R2: The virtual address is laid out {segment, page, offset} from MSB to LSB. The segment entry is read at st_base_i + segment. The page entry is read at the segment's page-table base + page. On success, paddr_o = {frame, offset}.
- R3: Segment entry layout: bit 11 present, bit 10 modified, bits 9:6 length in pages, bits 5:0 page-table base. Page entry layout: bit 5 valid, bits 4:0 frame.
- R4: A segment whose present bit is clear ends the walk with fault code 2. This check takes priority over the length check.
- R5: A page number greater than or equal to the segment length ends the walk with fault code 1. A page number of length minus one is accepted.
- R6: A page entry whose valid bit is clear ends the walk with fault code 3.
- R7: A write access that completes without a fault sets the modified bit of its segment entry and leaves the other fields unchanged. dirty_o reports the modified bit as read during that walk. A write access that faults does not set the bit.
- R8: A read access leaves the modified bit unchanged.
- R9: Timing is counted from the clock edge that accepts a request. A successful walk, or a page-entry fault, raises done_o 4 cycles later. A segment-level fault raises done_o 3 cycles later.
- R10: done_o lasts one cycle per request. fault_code_o is 0 on success. busy_o is high from the cycle after acceptance until the done cycle. req_i is ignored while busy_o is high.
- R11: A load-port write made while idle replaces the addressed table word, and later translations use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_base_i | input | 6 | Segment-table pointer (table memory word address) |
| ld_en_i | input | 1 | Load-port write strobe |
| ld_addr_i | input | 6 | Load-port word address |
| ld_data_i | input | 12 | Load-port write data |
| req_i | input | 1 | Translation request |
| req_write_i | input | 1 | Request is a write access |
| vaddr_i | input | 9 | Virtual address {segment, page, offset} |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completion is a fault |
| fault_code_o | output | 2 | 0 none, 1 length, 2 not present, 3 page invalid |
| paddr_o | output | 9 | Physical address {frame, offset} |
| dirty_o | output | 1 | Modified bit of the segment entry as read in this walk |

## Verification
The assertions assume that the load port is strobed only while busy_o is low. This keeps it from colliding with the modified-bit write-back. The driver waits for busy_o to fall before every load and every request. The latency checks assume that req_i is a clean level at the accepting edge. One stimulus holds req_i high into the busy period on purpose, with a changed address, to show that the extra cycle is ignored.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LEN    = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PAGE   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSEG, ST_CSEG, ST_RPAGE, ST_DONE, ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/xlate_mem.sv
module xlate_mem #(
  parameter int AW = 6,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 3,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 5,
  parameter int AW      = 6,
  localparam int LEN_W  = PAGE_W + 1,
  localparam int DW     = AW + LEN_W + 2,
  localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_write_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [AW-1:0]    st_base_i,
  output logic [AW-1:0]    mem_raddr_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             wb_en_o,
  output logic [AW-1:0]    wb_addr_o,
  output logic [DW-1:0]    wb_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             dirty_o
);
  localparam int PRES_B = DW - 1;
  localparam int MOD_B  = DW - 2;

  walk_state_e        state_q;
  logic [SEG_W-1:0]   seg_q;
  logic [PAGE_W-1:0]  page_q;
  logic [OFF_W-1:0]   off_q;
  logic               wr_q;
  logic [AW-1:0]      seg_addr_q;
  logic [DW-1:0]      sent_q;
  logic [PA_W-1:0]    paddr_q;
  fault_e             code_q;

  logic [LEN_W-1:0]   seg_len;
  logic [AW-1:0]      pt_base;
  logic               accept;

  assign seg_len = sent_q[AW +: LEN_W];
  assign pt_base = sent_q[AW-1:0];
  assign accept  = (state_q == ST_IDLE) && req_i;

  always_comb begin
    if (state_q == ST_IDLE)
      mem_raddr_o = st_base_i + AW'(vaddr_i[VA_W-1 -: SEG_W]);
    else
      mem_raddr_o = pt_base + AW'(page_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      seg_q      <= '0;
      page_q     <= '0;
      off_q      <= '0;
      wr_q       <= 1'b0;
      seg_addr_q <= '0;
      sent_q     <= '0;
      paddr_q    <= '0;
      code_q     <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          seg_q      <= vaddr_i[VA_W-1 -: SEG_W];
          page_q     <= vaddr_i[OFF_W +: PAGE_W];
          off_q      <= vaddr_i[OFF_W-1:0];
          wr_q       <= req_write_i;
          seg_addr_q <= mem_raddr_o;
          state_q    <= ST_RSEG;
        end
        ST_RSEG: begin
          sent_q  <= mem_rdata_i;
          state_q <= ST_CSEG;
        end
        ST_CSEG: begin
          // presence wins over length
          if (!sent_q[PRES_B]) begin
            code_q  <= FLT_ABSENT;
            state_q <= ST_FAULT;
          end else if ({1'b0, page_q} >= seg_len) begin
            code_q  <= FLT_LEN;
            state_q <= ST_FAULT;
          end else begin
            state_q <= ST_RPAGE;
          end
        end
        ST_RPAGE: begin
          if (!mem_rdata_i[FRAME_W]) begin
            code_q  <= FLT_PAGE;
            state_q <= ST_FAULT;
          end else begin
            code_q  <= FLT_NONE;
            paddr_q <= {mem_rdata_i[FRAME_W-1:0], off_q};
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // write-back of the segment entry with modified set
  assign wb_en_o      = (state_q == ST_DONE) && wr_q;
  assign wb_addr_o    = seg_addr_q;
  assign wb_data_o    = sent_q | (DW'(1) << MOD_B);

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fault_o      = (state_q == ST_FAULT);
  assign fault_code_o = code_q;
  assign paddr_o      = paddr_q;
  assign dirty_o      = sent_q[MOD_B];

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  // R10
  code_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (fault_code_o == FLT_NONE));
  // R9
  ok_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |-> $past(accept, 4));
  // R9
  seg_fault_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && fault_code_o != FLT_PAGE) |-> $past(accept, 3));
  // R5
  len_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && fault_code_o == FLT_LEN) |-> ({1'b0, page_q} >= seg_len));
  // R7
  wb_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> !fault_o);
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 3,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 5,
  parameter int AW      = 6,
  localparam int DW     = AW + PAGE_W + 3,
  localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   st_base_i,
  input  logic            ld_en_i,
  input  logic [AW-1:0]   ld_addr_i,
  input  logic [DW-1:0]   ld_data_i,
  input  logic            req_i,
  input  logic            req_write_i,
  input  logic [VA_W-1:0] vaddr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fault_o,
  output logic [1:0]      fault_code_o,
  output logic [PA_W-1:0] paddr_o,
  output logic            dirty_o
);
  logic [AW-1:0] raddr, wb_addr, waddr;
  logic [DW-1:0] rdata, wb_data, wdata;
  logic          wb_en, we;

  // internal write-back has priority over the load port
  assign we    = wb_en | ld_en_i;
  assign waddr = wb_en ? wb_addr : ld_addr_i;
  assign wdata = wb_en ? wb_data : ld_data_i;

  xlate_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  xlate_walk #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .FRAME_W(FRAME_W), .AW(AW)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .req_write_i  (req_write_i),
    .vaddr_i      (vaddr_i),
    .st_base_i    (st_base_i),
    .mem_raddr_o  (raddr),
    .mem_rdata_i  (rdata),
    .wb_en_o      (wb_en),
    .wb_addr_o    (wb_addr),
    .wb_data_o    (wb_data),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .paddr_o      (paddr_o),
    .dirty_o      (dirty_o)
  );

  // R11
  ld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |-> !busy_o);
  // R1
  fault_has_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
endmodule

// File: tb/sim_seg_page_xlate.sv
module sim_seg_page_xlate;
  typedef struct {
    bit         flt;
    bit [1:0]   code;
    bit [8:0]   pa;
    bit         dirty;
    int         lat;
    int         start;
    string      req;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic [5:0]  st_base = 6'd48;
  logic        ld_en = 0;
  logic [5:0]  ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic        req = 0, req_wr = 0;
  logic [8:0]  vaddr = '0;
  logic        busy, done, fault, dirty;
  logic [1:0]  code;
  logic [8:0]  paddr;

  int checks = 0, fails = 0, cyc = 0;
  logic [11:0] mdl [64];
  exp_t q[$];

  seg_page_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .st_base_i(st_base),
    .ld_en_i(ld_en), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .req_i(req), .req_write_i(req_wr), .vaddr_i(vaddr),
    .busy_o(busy), .done_o(done), .fault_o(fault),
    .fault_code_o(code), .paddr_o(paddr), .dirty_o(dirty)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] mk_seg(bit p, bit m, int len, int base);
    return {p, m, 4'(len), 6'(base)};
  endfunction

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic ld(int a, logic [11:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    ld_en = 1; ld_addr = 6'(a); ld_data = d; mdl[a] = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  // driver: model the walk, push expectation, issue request
  task automatic xl(int s, int p, int o, bit w, string r, bit hold = 0);
    exp_t e;
    int sa, pe_a;
    logic [11:0] se, pe;
    @(negedge clk);
    while (busy) @(negedge clk);
    sa = (int'(st_base) + s) % 64;
    se = mdl[sa];
    e.pa = '0; e.dirty = se[10]; e.req = r;
    if (!se[11]) begin e.flt = 1; e.code = 2; e.lat = 3; end
    else if (p >= int'(se[9:6])) begin e.flt = 1; e.code = 1; e.lat = 3; end
    else begin
      pe_a = (int'(se[5:0]) + p) % 64;
      pe = mdl[pe_a];
      e.lat = 4;
      if (!pe[5]) begin e.flt = 1; e.code = 3; end
      else begin
        e.flt = 0; e.code = 0; e.pa = {pe[4:0], 4'(o)};
        if (w) mdl[sa][10] = 1'b1;
      end
    end
    req = 1; req_wr = w; vaddr = {2'(s), 3'(p), 4'(o)};
    e.start = cyc;
    q.push_back(e);
    @(negedge clk);
    if (hold) begin
      vaddr = {2'd1, 3'd0, 4'd0}; req_wr = 1;
      @(negedge clk);
    end
    req = 0; req_wr = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(fault == e.flt && code == e.code, e.req, "fault/code",
            {fault, code}, {e.flt, e.code});
        if (!e.flt) begin
          chk(paddr == e.pa, e.req, "paddr", paddr, e.pa);
          chk(dirty == e.dirty, e.req, "dirty", dirty, e.dirty);
        end
        chk(cyc - e.start == e.lat, "R9", "latency", cyc - e.start, e.lat);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", "timeout", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy, "R1", "busy", busy, 0);
    chk(!done, "R1", "done", done, 0);
    chk(!fault, "R1", "fault", fault, 0);
    for (int i = 0; i < 64; i++) ld(i, 12'h0);
    // R3 table image
    ld(48, mk_seg(1, 0, 4, 0));
    ld(49, mk_seg(0, 0, 0, 16));
    ld(50, mk_seg(1, 0, 8, 8));
    ld(51, mk_seg(1, 0, 0, 0));
    ld(0, 12'h25); ld(1, 12'h26); ld(2, 12'h07); ld(3, 12'h28);
    for (int i = 0; i < 8; i++) ld(8 + i, 12'(32 + 16 + i));
    xl(0, 1, 10, 0, "R2");
    xl(0, 2, 0, 0, "R6");
    xl(0, 4, 0, 0, "R5");
    xl(0, 3, 15, 0, "R5");
    xl(1, 0, 0, 0, "R4");
    xl(3, 0, 0, 0, "R5");
    xl(2, 7, 3, 0, "R8");
    xl(2, 5, 1, 1, "R7");
    xl(2, 7, 2, 0, "R7");
    xl(0, 2, 0, 1, "R7");
    xl(0, 1, 4, 0, "R8");
    ld(1, 12'h3F);
    xl(0, 1, 9, 0, "R11");
    xl(2, 0, 6, 0, "R10", 1);
    st_base = 6'd52;
    ld(52, mk_seg(1, 0, 8, 8));
    xl(0, 6, 5, 1, "R2");
    xl(0, 6, 5, 0, "R7");
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "pending results", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule